// File: doc/BRIEF.md
# Buffer Flag Interrupt Generator

This block sits beside the transmit side of a small circular byte buffer and turns the read pointer's position into three status flags plus one shared interrupt line. The host reads the flags to learn which half of the buffer the transmitter has left, so that it can rewrite that half without colliding with the read pointer. It also learns when a full multi-pass block has been consumed.

Each flag has its own mask bit. Two of the flags request an interrupt on any change. The block-end flag requests one only when it rises. All enabled requests in a cycle merge into a single one-cycle pulse on the interrupt output. The buffer depth (28 bytes by default) and the number of buffer passes that make up one block (4 by default) are parameters.

Top module: `bfi_irq_gen`

## Requirements
- R1: Flag bit 1 (half flag) is high exactly when the address sampled at the previous clock edge lies in the upper half of the buffer, i.e. at or above DEPTH/2 (14 by default).
- R2: Flag bit 0 (toggle flag) inverts whenever the sampled address becomes DEPTH/2 from a different value, or becomes 0 from a different value. It holds its value otherwise, including on jumps that skip those two addresses.
- R3: Flag bit 2 (block-end flag) is high exactly when the sampled address is DEPTH-1 during the last pass of a block. Passes are counted modulo BLOCK_WRAPS, starting at 0 after reset, and advance each time the address becomes 0 from a different value.
- R4: With mask bit 0 (bit 1) set, each rising and each falling edge of flag bit 0 (bit 1) produces an interrupt pulse.
- R5: With mask bit 2 set, a rising edge of flag bit 2 produces an interrupt pulse and a falling edge does not.
- R6: A flag edge whose mask bit is clear produces no interrupt.
- R7: The interrupt output is high for one clock, in the cycle after the flag change becomes visible. Edges of several flags in the same cycle produce a single pulse.
- R8: While reset is low at a clock edge, all flags, the edge history and the interrupt are cleared. With the address held at 0, no interrupt follows the release of reset.
- R9: Changing mask bits while the flags are steady produces no interrupt.
- R10: Flags change one clock after the address that causes them is sampled. The mask is applied at the edge that registers the interrupt.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| rd_addr_i | input | ADDR_W (5) | Byte address the transmitter is reading |
| irq_mask_i | input | 3 | Per-flag interrupt enables, bit i gates flag bit i |
| flag_o | output | 3 | {block-end, half, toggle} flag levels |
| irq_o | output | 1 | One-cycle interrupt pulse |

## Verification
On every cycle, the assertions check the following: the half flag follows the sampled address, the toggle flag stays still while the address is steady, and the block-end flag appears only after the last address. They also check that steady flags or an all-clear mask never yield a pulse, that a falling block-end flag alone raises nothing, and that reset clears the outputs. Only the bench's scenarios can show the rest. These are the pass counting that places the block-end flag in the fourth pass, the toggle flag ignoring jumps that skip the trigger addresses, merged pulses from simultaneous edges, and the exact per-mask pulse sequence across full sweeps and a mid-run reset.

// File: rtl/bfi_pkg.sv
// Package: shared constants and edge rules for the buffer flag interrupt block.
// Assumes exactly three flags; index 2 is the rising-only block-end flag.
package bfi_pkg;
    localparam int NFLAG = 3;

    typedef enum logic {
        EDGE_BOTH = 1'b0,
        EDGE_RISE = 1'b1
    } edge_rule_e;

    // Edge rule per flag index: the block-end flag fires on rising only.
    function automatic edge_rule_e rule_of(input int idx);
        return (idx == NFLAG - 1) ? EDGE_RISE : EDGE_BOTH;
    endfunction
endpackage

// File: rtl/bfi_ptr_track.sv
// Module: follows the read pointer and produces the toggle and half flags.
// It also reports when the pointer re-enters byte 0 (a buffer wrap).
// Assumes rd_addr_i stays below DEPTH; reset is synchronous, active low.
module bfi_ptr_track #(
    parameter int DEPTH  = 28,
    parameter int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic              toggle_o,
    output logic              half_o,
    output logic              wrap_o
);
    localparam logic [ADDR_W-1:0] MID_A  = ADDR_W'(DEPTH / 2);
    localparam logic [ADDR_W-1:0] ZERO_A = '0;

    logic [ADDR_W-1:0] prev_q;
    logic              tog_q;
    logic              half_q;
    logic              enter_mid;
    logic              enter_zero;

    // Detect arrival at the midpoint or at byte 0 from another address.
    always_comb begin
        enter_mid  = (rd_addr_i == MID_A)  && (prev_q != MID_A);
        enter_zero = (rd_addr_i == ZERO_A) && (prev_q != ZERO_A);
    end

    // Register the address history and both flag levels.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= '0;
            tog_q  <= 1'b0;
            half_q <= 1'b0;
        end else begin
            prev_q <= rd_addr_i;
            tog_q  <= tog_q ^ (enter_mid | enter_zero);
            half_q <= (rd_addr_i >= MID_A);
        end
    end

    assign toggle_o = tog_q;
    assign half_o   = half_q;
    assign wrap_o   = enter_zero;

    // R1: an upper-half address shows on the half flag one clock later.
    p_half_upper_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr_i >= MID_A) |=> half_o);
    p_half_lower_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr_i < MID_A) |=> !half_o);
    // R2: a steady address never inverts the toggle flag.
    p_toggle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(rd_addr_i) |=> $stable(toggle_o));
endmodule

// File: rtl/bfi_block_end.sv
// Module: counts buffer passes and raises the block-end flag when the
// pointer sits on the last byte during the final pass of a block.
// Assumes wrap_i pulses for one cycle as the pointer re-enters byte 0.
module bfi_block_end #(
    parameter int DEPTH       = 28,
    parameter int BLOCK_WRAPS = 4,
    parameter int ADDR_W      = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] rd_addr_i,
    input  logic              wrap_i,
    output logic              end_o
);
    localparam int                CNT_W     = (BLOCK_WRAPS > 1) ? $clog2(BLOCK_WRAPS) : 1;
    localparam logic [CNT_W-1:0]  LAST_PASS = CNT_W'(BLOCK_WRAPS - 1);
    localparam logic [ADDR_W-1:0] LAST_A    = ADDR_W'(DEPTH - 1);

    logic [CNT_W-1:0] pass_q;
    logic             end_q;

    // Advance the pass counter on each wrap, modulo BLOCK_WRAPS.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pass_q <= '0;
        end else if (wrap_i) begin
            pass_q <= (pass_q == LAST_PASS) ? '0 : pass_q + 1'b1;
        end
    end

    // Register the block-end level from the address and the current pass.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            end_q <= 1'b0;
        end else begin
            end_q <= (rd_addr_i == LAST_A) && (pass_q == LAST_PASS);
        end
    end

    assign end_o = end_q;

    // R3: the block-end flag only follows a sample of the last address.
    p_end_at_last_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr_i != LAST_A) |=> !end_o);
endmodule

// File: rtl/bfi_edge_qual.sv
// Module: keeps the previous flag levels and forms the masked per-flag
// edge requests, using the edge rule that the package gives each flag.
// Assumes flag_i is registered upstream; the output is combinational.
module bfi_edge_qual
    import bfi_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NFLAG-1:0] flag_i,
    input  logic [NFLAG-1:0] mask_i,
    output logic [NFLAG-1:0] hit_o
);
    logic [NFLAG-1:0] flag_d;

    // Hold last cycle's flag levels for edge comparison.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_d <= '0;
        end else begin
            flag_d <= flag_i;
        end
    end

    // Build one request per flag from its edge rule and mask bit.
    for (genvar i = 0; i < NFLAG; i++) begin : g_flag
        if (rule_of(i) == EDGE_BOTH) begin : g_both
            assign hit_o[i] = mask_i[i] & (flag_i[i] ^ flag_d[i]);
        end else begin : g_rise
            assign hit_o[i] = mask_i[i] & flag_i[i] & ~flag_d[i];
        end
    end
endmodule

// File: rtl/bfi_irq_gen.sv
// Module (top): buffer flag interrupt generator. Derives the three flags
// from the read pointer and merges the enabled flag edges into one
// single-cycle interrupt pulse. Assumes rd_addr_i < DEPTH, DEPTH even,
// and a synchronous active-low reset.
module bfi_irq_gen
    import bfi_pkg::*;
#(
    parameter int DEPTH       = 28,
    parameter int BLOCK_WRAPS = 4,
    parameter int ADDR_W      = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] rd_addr_i,
    input  logic [NFLAG-1:0]  irq_mask_i,
    output logic [NFLAG-1:0]  flag_o,
    output logic              irq_o
);
    logic             toggle;
    logic             half;
    logic             wrap;
    logic             blk_end;
    logic [NFLAG-1:0] hit;
    logic             irq_q;

    bfi_ptr_track #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_addr_i(rd_addr_i),
        .toggle_o (toggle),
        .half_o   (half),
        .wrap_o   (wrap)
    );

    bfi_block_end #(.DEPTH(DEPTH), .BLOCK_WRAPS(BLOCK_WRAPS), .ADDR_W(ADDR_W)) u_blk (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_addr_i(rd_addr_i),
        .wrap_i   (wrap),
        .end_o    (blk_end)
    );

    assign flag_o = {blk_end, half, toggle};

    bfi_edge_qual u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .flag_i(flag_o),
        .mask_i(irq_mask_i),
        .hit_o (hit)
    );

    // Merge all requests of a cycle into a single registered pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
        end else begin
            irq_q <= |hit;
        end
    end

    assign irq_o = irq_q;

    // R9: flags steady over the last cycle give no pulse.
    p_steady_no_irq_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(flag_o) |=> !irq_o);
    // R6: an all-clear mask gives no pulse.
    p_mask_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_mask_i == '0) |=> !irq_o);
    // R5: a lone falling block-end flag gives no pulse.
    p_fall_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(flag_o[2]) && $stable(flag_o[1:0])) |=> !irq_o);
    // R4: an enabled change on the toggle flag always pulses.
    p_toggle_edge_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(flag_o[0]) && irq_mask_i[0]) |=> irq_o);
    // R8: reset clears flags and interrupt.
    p_reset_clear_r8: assert property (@(posedge clk)
        !rst_n |=> (irq_o == 1'b0 && flag_o == '0));
endmodule

// File: tb/sim_bfi_irq_gen.sv
// Scoreboard bench: the driver task applies inputs, computes the expected
// outputs from the requirements and queues them; the monitor pops and compares.
module sim_bfi_irq_gen;
    localparam int DEPTH = 28;
    localparam int WRAPS = 4;
    localparam int AW    = 5;
    localparam int MID   = DEPTH / 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [2:0]    mask = '0;
    logic [2:0]    flag;
    logic          irq;

    int tests = 0;
    int fails = 0;

    bfi_irq_gen #(.DEPTH(DEPTH), .BLOCK_WRAPS(WRAPS)) u0 (
        .clk(clk), .rst_n(rst_n), .rd_addr_i(addr),
        .irq_mask_i(mask), .flag_o(flag), .irq_o(irq)
    );

    always #10 clk = ~clk;

    typedef struct packed {
        logic [2:0] f;
        logic       irq;
    } exp_t;

    exp_t  exp_q[$];
    string tag_q[$];

    // model state
    int         m_prev = 0;
    int         m_pass = 0;
    logic       m_tog  = 1'b0;
    logic [2:0] m_fq   = '0;
    logic [2:0] m_fd   = '0;

    task automatic model_reset();
        m_prev = 0; m_pass = 0; m_tog = 1'b0; m_fq = '0; m_fd = '0;
    endtask

    task automatic check(input string req, input int act, input int expv);
        tests++;
        if (act != expv) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, expv, $time);
        end
    endtask

    // Driver: apply one address/mask pair and queue the outcome (R10 timing:
    // flags one edge later, the pulse one edge after that).
    task automatic drive(input int a, input logic [2:0] m, input string tag);
        logic wrap_e, f0n, f1n, f2n;
        logic [2:0] edges;
        @(negedge clk);
        addr = AW'(a);
        mask = m;
        wrap_e = (a == 0) && (m_prev != 0);
        f0n = m_tog ^ (((a == MID) && (m_prev != MID)) || wrap_e);
        f1n = (a >= MID);
        f2n = (a == DEPTH - 1) && (m_pass == WRAPS - 1);
        edges = ((m_fq ^ m_fd) & 3'b011) | (m_fq & ~m_fd & 3'b100);
        exp_q.push_back('{f: m_fq == m_fq ? {f2n, f1n, f0n} : 3'b0, irq: |(edges & m)});
        tag_q.push_back(tag);
        if (wrap_e) m_pass = (m_pass + 1) % WRAPS;
        m_prev = a;
        m_tog  = f0n;
        m_fd   = m_fq;
        m_fq   = {f2n, f1n, f0n};
    endtask

    // Monitor: compare after each active edge.
    always @(posedge clk) begin
        #5;
        if (exp_q.size() > 0) begin
            exp_t  e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check("R2 toggle flag", int'(flag[0]), int'(e.f[0]));
            check("R1 half flag",   int'(flag[1]), int'(e.f[1]));
            check("R3 block-end",   int'(flag[2]), int'(e.f[2]));
            check({t, " irq (R7)"}, int'(irq), int'(e.irq));
        end
    end

    task automatic sweep(input int passes, input logic [2:0] m, input string tag);
        for (int p = 0; p < passes; p++)
            for (int a = 0; a < DEPTH; a++)
                drive(a, m, tag);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R8 reset flags", int'(flag), 0);
        check("R8 reset irq",   int'(irq),  0);
        addr  = '0;
        rst_n = 1'b1;
        model_reset();
    endtask

    logic done = 1'b0;

    initial begin
        repeat (3) @(negedge clk);
        check("R8 reset flags", int'(flag), 0);
        check("R8 reset irq",   int'(irq),  0);
        rst_n = 1'b1;
        // R8: quiet cycles after release
        repeat (3) drive(0, 3'b111, "R8");
        // R4 R5 R7: all enabled, full block of passes
        sweep(WRAPS + 1, 3'b111, "R4");
        // R5: block-end only, rising edges pulse, falling edges do not
        sweep(WRAPS, 3'b100, "R5");
        // R4: toggle flag only
        sweep(2, 3'b001, "R4");
        // R4: half flag only
        sweep(1, 3'b010, "R4");
        // R6: all masked
        sweep(WRAPS, 3'b000, "R6");
        // R9: mask changes with address steady
        for (int k = 0; k < 8; k++) drive(20, 3'(k), "R9");
        // R2: jumps that skip or hit the trigger addresses
        drive(5, 3'b111, "R2");
        drive(20, 3'b111, "R2");
        drive(3, 3'b111, "R2");
        drive(MID, 3'b111, "R2");
        drive(MID, 3'b111, "R2");
        drive(0, 3'b111, "R2");
        drive(0, 3'b111, "R2");
        // R7: 13 -> 14 flips two flags at once, one pulse
        drive(13, 3'b011, "R7");
        drive(MID, 3'b011, "R7");
        drive(MID, 3'b011, "R7");
        drive(MID, 3'b011, "R7");
        // R8: reset in mid-run with flags set
        do_reset();
        repeat (3) drive(0, 3'b111, "R8");
        sweep(1, 3'b111, "R10");
        repeat (3) @(negedge clk);
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                tests++;
                fails++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule